// File: doc/BRIEF.md
# Bit-Band Alias Bridge

This bridge sits between a processor-side request bus and a downstream memory or peripheral bus. It carves out an alias window in which every 32-bit word stands for a single bit of a smaller target region. A read inside the window turns into a word read of the target. The chosen bit comes back in bit 0 of the read data, one cycle after the request, exactly like a normal load.

A write inside the window is accepted in the cycle it is presented. The bridge then runs a locked pair of downstream accesses: a read of the target word in the accept cycle, and a write of the same word in the next cycle. Between the two, the addressed bit is replaced by bit 0 of the write data. Any upstream request presented during that second cycle is held off for one cycle. Accesses outside the window reach the downstream bus combinationally with their address, data, byte enables and direction unchanged.

The downstream bus is assumed to accept one access per cycle and to return read data in the cycle after a read request.

Top module: `bb_bridge`

## Requirements
- R1: During and after reset, with no upstream request, `up_ready_o` is 1, `up_rvalid_o` is 0 and `dn_req_o` is 0.
- R2: An upstream access to an alias address A (ALIAS_BASE <= A < ALIAS_BASE + 32*REGION_BYTES) is issued downstream as a full-word read (`dn_we_o`=0, `dn_be_o`=4'hF). Its address is REGION_BASE + 4*floor((A-ALIAS_BASE)/128).
- R3: For an accepted alias read, `up_rvalid_o` is 1 in the next cycle, and `up_rdata_o` is 31 zero bits above the target word's bit ((A-ALIAS_BASE)>>2) mod 32.
- R4: An alias write is accepted (`up_ready_o`=1) in the cycle it is presented, unless a read-modify-write is finishing. The downstream read of the target word is issued in that same cycle, and the write returns no read data.
- R5: In the cycle after an accepted alias write, the bridge issues a downstream write with all byte enables set, to the same word address as the read of the previous cycle.
- R6: The merged write data equals the word just read, with the addressed bit replaced by bit 0 of the upstream write data. Write data bits 31..1 are ignored.
- R7: While the downstream write of a read-modify-write is in flight, `up_ready_o` is 0. A request held there is issued unchanged in the following cycle.
- R8: An access outside the alias window drives `dn_addr_o`, `dn_we_o`, `dn_wdata_o` and `dn_be_o` equal to the upstream values in the same cycle. A read returns the downstream word unchanged one cycle later.
- R9: Back-to-back accesses that are not alias writes are accepted every cycle without a stall.
- R10: The window is bounded exactly. The first and last alias words hit (they map to bit 0 of the first target word and bit 31 of the last), and the words just below and just above the window pass through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| up_req_i | input | 1 | Upstream access request |
| up_we_i | input | 1 | Upstream write (1) or read (0) |
| up_addr_i | input | 32 | Upstream byte address |
| up_wdata_i | input | 32 | Upstream write data |
| up_be_i | input | 4 | Upstream byte enables |
| up_ready_o | output | 1 | Request accepted this cycle |
| up_rvalid_o | output | 1 | Read data valid (cycle after accept) |
| up_rdata_o | output | 32 | Read data to upstream |
| dn_req_o | output | 1 | Downstream access request |
| dn_we_o | output | 1 | Downstream write (1) or read (0) |
| dn_addr_o | output | 32 | Downstream byte address |
| dn_wdata_o | output | 32 | Downstream write data |
| dn_be_o | output | 4 | Downstream byte enables |
| dn_rdata_i | input | 32 | Downstream read data (cycle after a read) |

## Verification
The bridge holds little state: a pending read-modify-write with its word address, bit number and new bit value, plus a pending read flag that records whether the read is an alias read. Suppose a stale or wrong bit index is latched. It shows up one cycle later, either as the wrong bit in bit 0 of alias read data or as a wrong bit flipped in the downstream write. The bench's memory model then exposes that write on the next read-back. Suppose instead the pending read-modify-write flag is wrong. That shows in the very next cycle, as a missing or spurious stall on `up_ready_o` or as a downstream write to an unexpected address. The timing test watches those port values cycle by cycle.

// File: rtl/bb_pkg.sv
`timescale 1ns/1ps
package bb_pkg;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int BE_W   = DATA_W / 8;
    localparam int BIT_W  = $clog2(DATA_W);

    typedef struct packed {
        logic              rmw_pend;   // downstream write of a read-modify-write due now
        logic              rd_pend;    // read data due to upstream now
        logic              rd_alias;   // pending read is an alias read
        logic [BIT_W-1:0]  bit_sel;    // bit to pick or merge
        logic              bit_val;    // new bit value for a read-modify-write
        logic [ADDR_W-1:0] rmw_addr;   // target word of the read-modify-write
    } bb_state_t;
endpackage

// File: rtl/bb_decode.sv
`timescale 1ns/1ps
module bb_decode
    import bb_pkg::*;
#(
    parameter logic [ADDR_W-1:0] ALIAS_BASE   = 32'h2200_0000,
    parameter logic [ADDR_W-1:0] REGION_BASE  = 32'h2000_0000,
    parameter logic [ADDR_W-1:0] REGION_BYTES = 32'd64
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_o,
    output logic [ADDR_W-1:0] tgt_addr_o,
    output logic [BIT_W-1:0]  bit_idx_o
);
    // Each region byte owns 8 alias words of 4 bytes, i.e. 32 alias bytes.
    localparam logic [ADDR_W-1:0] WIN_BYTES = REGION_BYTES << 5;
    localparam int                WSH       = BIT_W + 2;   // alias bytes per target word = 2**WSH

    logic [ADDR_W-1:0] off;

    always_comb begin
        off        = addr_i - ALIAS_BASE;
        hit_o      = (off < WIN_BYTES);
        tgt_addr_o = REGION_BASE + {{(WSH-2){1'b0}}, off[ADDR_W-1:WSH], 2'b00};
        bit_idx_o  = off[WSH-1:2];
    end
endmodule

// File: rtl/bb_bitop.sv
`timescale 1ns/1ps
module bb_bitop
    import bb_pkg::*;
(
    input  logic [DATA_W-1:0] word_i,
    input  logic [BIT_W-1:0]  bit_idx_i,
    input  logic              val_i,
    output logic [DATA_W-1:0] merged_o,
    output logic              picked_o
);
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign merged_o[i] = (bit_idx_i == BIT_W'(i)) ? val_i : word_i[i];
    end

    assign picked_o = word_i[bit_idx_i];
endmodule

// File: rtl/bb_bridge.sv
`timescale 1ns/1ps
module bb_bridge
    import bb_pkg::*;
#(
    parameter logic [ADDR_W-1:0] ALIAS_BASE   = 32'h2200_0000,
    parameter logic [ADDR_W-1:0] REGION_BASE  = 32'h2000_0000,
    parameter logic [ADDR_W-1:0] REGION_BYTES = 32'd64
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              up_req_i,
    input  logic              up_we_i,
    input  logic [ADDR_W-1:0] up_addr_i,
    input  logic [DATA_W-1:0] up_wdata_i,
    input  logic [BE_W-1:0]   up_be_i,
    output logic              up_ready_o,
    output logic              up_rvalid_o,
    output logic [DATA_W-1:0] up_rdata_o,
    output logic              dn_req_o,
    output logic              dn_we_o,
    output logic [ADDR_W-1:0] dn_addr_o,
    output logic [DATA_W-1:0] dn_wdata_o,
    output logic [BE_W-1:0]   dn_be_o,
    input  logic [DATA_W-1:0] dn_rdata_i
);
    bb_state_t st_d, st_q;

    logic              hit;
    logic [ADDR_W-1:0] tgt_addr;
    logic [BIT_W-1:0]  bit_idx;
    logic [DATA_W-1:0] merged;
    logic              picked;

    bb_decode #(
        .ALIAS_BASE  (ALIAS_BASE),
        .REGION_BASE (REGION_BASE),
        .REGION_BYTES(REGION_BYTES)
    ) u_decode (
        .addr_i    (up_addr_i),
        .hit_o     (hit),
        .tgt_addr_o(tgt_addr),
        .bit_idx_o (bit_idx)
    );

    // One bit unit serves both the merge and the pick: a cycle holds either a
    // read-modify-write completion or a read return, never both.
    bb_bitop u_bitop (
        .word_i   (dn_rdata_i),
        .bit_idx_i(st_q.bit_sel),
        .val_i    (st_q.bit_val),
        .merged_o (merged),
        .picked_o (picked)
    );

    always_comb begin
        st_d          = st_q;
        st_d.rmw_pend = 1'b0;
        st_d.rd_pend  = 1'b0;

        up_ready_o = ~st_q.rmw_pend;
        dn_req_o   = 1'b0;
        dn_we_o    = 1'b0;
        dn_addr_o  = up_addr_i;
        dn_wdata_o = up_wdata_i;
        dn_be_o    = up_be_i;

        if (st_q.rmw_pend) begin
            // second half of the locked pair: write back the merged word
            dn_req_o   = 1'b1;
            dn_we_o    = 1'b1;
            dn_addr_o  = st_q.rmw_addr;
            dn_wdata_o = merged;
            dn_be_o    = '1;
        end else if (up_req_i) begin
            dn_req_o = 1'b1;
            if (hit) begin
                dn_we_o       = 1'b0;
                dn_addr_o     = tgt_addr;
                dn_be_o       = '1;
                st_d.bit_sel  = bit_idx;
                st_d.bit_val  = up_wdata_i[0];
                st_d.rmw_addr = tgt_addr;
                st_d.rmw_pend = up_we_i;
                st_d.rd_pend  = ~up_we_i;
                st_d.rd_alias = 1'b1;
            end else begin
                dn_we_o       = up_we_i;
                st_d.rd_pend  = ~up_we_i;
                st_d.rd_alias = 1'b0;
            end
        end

        up_rvalid_o = st_q.rd_pend;
        up_rdata_o  = st_q.rd_alias ? {{(DATA_W-1){1'b0}}, picked} : dn_rdata_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end
endmodule

// File: rtl/bb_bridge_chk.sv
`timescale 1ns/1ps
module bb_bridge_chk
    import bb_pkg::*;
#(
    parameter logic [ADDR_W-1:0] ALIAS_BASE   = 32'h2200_0000,
    parameter logic [ADDR_W-1:0] REGION_BASE  = 32'h2000_0000,
    parameter logic [ADDR_W-1:0] REGION_BYTES = 32'd64
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              up_req_i,
    input logic              up_we_i,
    input logic [ADDR_W-1:0] up_addr_i,
    input logic [DATA_W-1:0] up_wdata_i,
    input logic [BE_W-1:0]   up_be_i,
    input logic              up_ready_o,
    input logic              up_rvalid_o,
    input logic [DATA_W-1:0] up_rdata_o,
    input logic              dn_req_o,
    input logic              dn_we_o,
    input logic [ADDR_W-1:0] dn_addr_o,
    input logic [DATA_W-1:0] dn_wdata_o,
    input logic [BE_W-1:0]   dn_be_o,
    input logic [DATA_W-1:0] dn_rdata_i
);
    logic [ADDR_W-1:0] c_off;
    logic              c_hit, acc, acc_aw, acc_ar;

    assign c_off  = up_addr_i - ALIAS_BASE;
    assign c_hit  = (c_off < (REGION_BYTES * 32));
    assign acc    = rst_ni && up_req_i && up_ready_o;
    assign acc_aw = acc && c_hit && up_we_i;
    assign acc_ar = acc && c_hit && !up_we_i;

    // R1: no downstream traffic without a request or a pending completion
    a_r1_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!up_req_i && up_ready_o) |-> !dn_req_o);

    // R2: alias accesses go downstream as full-word reads of the target word
    a_r2_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (acc && c_hit) |-> (dn_req_o && !dn_we_o && dn_be_o == '1 &&
            dn_addr_o == REGION_BASE + {5'd0, c_off[ADDR_W-1:7], 2'b00}));

    // R3: alias read data is the selected bit in bit 0
    a_r3_extract: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(acc_ar) |-> (up_rvalid_o &&
            up_rdata_o == {31'd0, dn_rdata_i[$past(c_off[6:2])]}));

    // R5: write half of the pair targets the same word with all byte enables
    a_r5_same_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
        acc_aw |=> (dn_req_o && dn_we_o && dn_be_o == '1 && dn_addr_o == $past(dn_addr_o)));

    // R6: merged data replaces only the addressed bit
    a_r6_merge: assert property (@(posedge clk_i) disable iff (!rst_ni)
        acc_aw |=> (dn_wdata_o ==
            ((dn_rdata_i & ~(32'd1 << $past(c_off[6:2]))) |
             ({31'd0, $past(up_wdata_i[0])} << $past(c_off[6:2])))));

    // R7: upstream held off during the write half; R4 write gives no read data
    a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        acc_aw |=> (!up_ready_o && !up_rvalid_o));

    // R9: no stall unless a read-modify-write is completing
    a_r9_no_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(acc_aw) |-> up_ready_o);

    // R8: pass-through is transparent
    a_r8_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (acc && !c_hit) |-> (dn_req_o && dn_we_o == up_we_i && dn_addr_o == up_addr_i &&
            dn_wdata_o == up_wdata_i && dn_be_o == up_be_i));
endmodule

bind bb_bridge bb_bridge_chk #(
    .ALIAS_BASE  (ALIAS_BASE),
    .REGION_BASE (REGION_BASE),
    .REGION_BYTES(REGION_BYTES)
) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .up_req_i   (up_req_i),
    .up_we_i    (up_we_i),
    .up_addr_i  (up_addr_i),
    .up_wdata_i (up_wdata_i),
    .up_be_i    (up_be_i),
    .up_ready_o (up_ready_o),
    .up_rvalid_o(up_rvalid_o),
    .up_rdata_o (up_rdata_o),
    .dn_req_o   (dn_req_o),
    .dn_we_o    (dn_we_o),
    .dn_addr_o  (dn_addr_o),
    .dn_wdata_o (dn_wdata_o),
    .dn_be_o    (dn_be_o),
    .dn_rdata_i (dn_rdata_i)
);

// File: tb/bb_bridge_bench.sv
`timescale 1ns/1ps
module bb_bridge_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        up_req = 1'b0, up_we = 1'b0;
    logic [31:0] up_addr = '0, up_wdata = '0;
    logic [3:0]  up_be = 4'hF;
    logic        up_ready, up_rvalid;
    logic [31:0] up_rdata;
    logic        dn_req, dn_we;
    logic [31:0] dn_addr, dn_wdata;
    logic [3:0]  dn_be;
    logic [31:0] dn_rdata;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    bb_bridge u_bb_bridge (
        .clk_i(clk), .rst_ni(rst_n),
        .up_req_i(up_req), .up_we_i(up_we), .up_addr_i(up_addr),
        .up_wdata_i(up_wdata), .up_be_i(up_be),
        .up_ready_o(up_ready), .up_rvalid_o(up_rvalid), .up_rdata_o(up_rdata),
        .dn_req_o(dn_req), .dn_we_o(dn_we), .dn_addr_o(dn_addr),
        .dn_wdata_o(dn_wdata), .dn_be_o(dn_be), .dn_rdata_i(dn_rdata)
    );

    // Downstream memory model: region words at idx 0..15, peripheral words at 16..31.
    logic [31:0] mem [32];
    logic [4:0]  midx;
    assign midx = {dn_addr[30], dn_addr[5:2]};

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 32; i++) mem[i] <= '0;
            dn_rdata <= '0;
        end else if (dn_req) begin
            if (dn_we) begin
                for (int b = 0; b < 4; b++)
                    if (dn_be[b]) mem[midx][8*b +: 8] <= dn_wdata[8*b +: 8];
            end else begin
                dn_rdata <= mem[midx];
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic [31:0] addr, input logic [31:0] wd,
                          input logic [3:0] be, output logic rv, output logic [31:0] rd);
        @(negedge clk);
        up_req = 1'b1; up_we = we; up_addr = addr; up_wdata = wd; up_be = be;
        #1;
        while (!up_ready) begin
            @(negedge clk); #1;
        end
        @(posedge clk);
        @(negedge clk);
        up_req = 1'b0;
        rv = up_rvalid;
        rd = up_rdata;
    endtask

    typedef struct packed {
        logic        we;
        logic [31:0] addr;
        logic [31:0] wdata;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 32'h2000_0004, 32'h8000_0011, 32'h0,          8'd8 },  // R8 pass write
        '{1'b0, 32'h2200_0080, 32'h0,          32'h1,          8'd3 },  // R3 word1 bit0
        '{1'b0, 32'h2200_0084, 32'h0,          32'h0,          8'd3 },  // R3 word1 bit1
        '{1'b0, 32'h2200_00FC, 32'h0,          32'h1,          8'd3 },  // R3 word1 bit31
        '{1'b0, 32'h2200_0090, 32'h0,          32'h1,          8'd3 },  // R3 word1 bit4
        '{1'b1, 32'h2200_0084, 32'h1,          32'h0,          8'd6 },  // R6 set bit1
        '{1'b0, 32'h2000_0004, 32'h0,          32'h8000_0013,  8'd6 },
        '{1'b1, 32'h2200_00FC, 32'hFFFF_FFFE,  32'h0,          8'd6 },  // R6 clear, upper bits ignored
        '{1'b0, 32'h2000_0004, 32'h0,          32'h0000_0013,  8'd6 },
        '{1'b1, 32'h2200_07FC, 32'h1,          32'h0,          8'd10},  // R10 last alias word
        '{1'b0, 32'h2000_003C, 32'h0,          32'h8000_0000,  8'd10},
        '{1'b1, 32'h4000_0008, 32'h1234_5678,  32'h0,          8'd8 },
        '{1'b0, 32'h4000_0008, 32'h0,          32'h1234_5678,  8'd8 },
        '{1'b1, 32'h2200_0000, 32'h1,          32'h0,          8'd10},  // R10 first alias word
        '{1'b0, 32'h2000_0000, 32'h0,          32'h1,          8'd10},
        '{1'b0, 32'h21FF_FFFC, 32'h0,          32'h8000_0000,  8'd10},  // R10 just below
        '{1'b1, 32'h2200_0800, 32'hDEAD_BEEF,  32'h0,          8'd10},  // R10 just above
        '{1'b0, 32'h2000_0000, 32'h0,          32'hDEAD_BEEF,  8'd10},
        '{1'b0, 32'h2200_07FC, 32'h0,          32'h1,          8'd10}
    };

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic        rv;
        logic [31:0] rd;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 ready in reset", {31'd0, up_ready}, 32'd1);
        chk("R1 rvalid in reset", {31'd0, up_rvalid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready after reset", {31'd0, up_ready}, 32'd1);
        chk("R1 no downstream request", {31'd0, dn_req}, 32'd0);

        // table walk
        for (int k = 0; k < NV; k++) begin
            access(VEC[k].we, VEC[k].addr, VEC[k].wdata, 4'hF, rv, rd);
            if (VEC[k].we) begin
                chk($sformatf("R4 no read data on write vec%0d", k), {31'd0, rv}, 32'd0);
            end else begin
                chk($sformatf("R%0d rvalid vec%0d", VEC[k].req, k), {31'd0, rv}, 32'd1);
                chk($sformatf("R%0d rdata vec%0d", VEC[k].req, k), rd, VEC[k].exp);
            end
        end

        // R2: alias read address and byte enables (word1 bit4)
        @(negedge clk);
        up_req = 1'b1; up_we = 1'b0; up_addr = 32'h2200_0090; up_be = 4'h3;
        #1;
        chk("R2 target address", dn_addr, 32'h2000_0004);
        chk("R2 full word read", {27'd0, dn_we, dn_be}, 32'h0000_000F);
        @(negedge clk);
        up_req = 1'b0; up_be = 4'hF;

        // R4, R5, R7: read-modify-write timing with an overlapping request
        @(negedge clk);
        up_req = 1'b1; up_we = 1'b1; up_addr = 32'h2200_0104; up_wdata = 32'h1;
        #1;
        chk("R4 accepted at once", {31'd0, up_ready}, 32'd1);
        chk("R4 downstream read issued", {30'd0, dn_req, dn_we}, 32'h2);
        chk("R4 read address", dn_addr, 32'h2000_0008);
        @(negedge clk);
        up_we = 1'b0; up_addr = 32'h2000_0008;
        #1;
        chk("R7 held off", {31'd0, up_ready}, 32'd0);
        chk("R5 downstream write", {30'd0, dn_req, dn_we}, 32'h3);
        chk("R5 same word", dn_addr, 32'h2000_0008);
        chk("R5 full enables", {28'd0, dn_be}, 32'hF);
        @(negedge clk);
        #1;
        chk("R7 released", {31'd0, up_ready}, 32'd1);
        chk("R7 held request issued", {dn_addr[31:1], dn_we}, 32'h2000_0008);
        @(negedge clk);
        chk("R6 merged value read back", up_rdata, 32'h0000_0002);
        up_req = 1'b0;

        // R9: back-to-back reads, no stall
        @(negedge clk);
        up_req = 1'b1; up_we = 1'b0; up_addr = 32'h4000_0008;
        #1; chk("R9 ready 1", {31'd0, up_ready}, 32'd1);
        @(negedge clk);
        chk("R9 data 1", up_rdata, 32'h1234_5678);
        up_addr = 32'h2000_0004;
        #1; chk("R9 ready 2", {31'd0, up_ready}, 32'd1);
        @(negedge clk);
        chk("R9 data 2", up_rdata, 32'h0000_0013);
        up_addr = 32'h2200_0090;
        #1; chk("R9 ready 3", {31'd0, up_ready}, 32'd1);
        @(negedge clk);
        chk("R9 data 3", up_rdata, 32'h1);
        up_req = 1'b0;

        // R8: byte enables pass through
        access(1'b1, 32'h4000_000C, 32'hAABB_CCDD, 4'h1, rv, rd);
        access(1'b0, 32'h4000_000C, 32'h0, 4'hF, rv, rd);
        chk("R8 byte enable honoured", rd, 32'h0000_00DD);

        finish_run();
    end
endmodule